// File: doc/BRIEF.md
# 16-bit Timer with Input Capture and PWM

This block is a 16-bit timer/counter driven by a selectable clock-enable prescaler. In its normal mode it counts upward, wraps from 0xFFFF to zero and raises a wrap flag. A compare register raises a match flag whenever the count meets it, and a waveform pin toggles on each match. A capture input passes through a two-stage synchroniser and an optional four-sample noise filter. A qualified edge of the chosen polarity copies the running count into a capture register and raises a capture flag.

In its PWM modes the counter runs up to a top value of 0x00FF, 0x01FF or 0x03FF (8-, 9- or 10-bit resolution) and then back down to zero. The waveform pin is driven low by a compare match on the way up and high by a match on the way down. This gives a symmetric pulse whose high time per period is twice the compare value.

Software reaches the block through a simple write port and a combinational read port. The three flags are exported as level interrupt requests. Each flag is cleared by writing a 1 to its bit.

Top module: `cap_pwm_timer16`

## Requirements
- R1: After reset, the control, count, compare and capture registers, the flag register, the waveform pin and all three interrupt outputs are zero, so the counter is stopped.
- R2: Control bits [1:0] select the count enable: 0 stops the counter, 1 counts every clock, 2 counts once every 8 clocks and 3 counts once every 64 clocks. The first increment comes one clock after the control write takes effect.
- R3: In normal mode (control bits [3:2] = 0), a counting step from 0xFFFF goes to 0x0000 and sets the wrap flag (flag bit 0, output irq_ovf).
- R4: A counting step taken while the count equals the compare register sets the match flag (flag bit 1, output irq_cmp). In normal mode the same step inverts cmp_pin.
- R5: A qualified capture edge copies the current count into the capture register and sets the capture flag (flag bit 2, output irq_cap). Control bit 4 = 1 selects rising edges and 0 selects falling edges. An edge of the other polarity changes neither the capture register nor the flag.
- R6: With control bit 5 = 0, any change of the synchronised input counts as an edge, so a one-clock pulse is captured. With bit 5 = 1, a new level is accepted only after four consecutive equal samples, so a three-clock pulse is ignored and a four-clock pulse is captured.
- R7: In PWM mode (control bits [3:2] = 1, 2 or 3 for TOP = 0x00FF, 0x01FF or 0x03FF), after a control write the counter starts upward from its value. It reverses at TOP, reverses again at zero, moves by exactly one per step and never exceeds TOP.
- R8: In PWM mode with compare value C ≤ TOP, a match while counting up drives cmp_pin low and a match while counting down drives it high. A match at TOP counts as downward and a match at zero counts as upward, so cmp_pin is high for exactly 2·C of every 2·TOP counting clocks.
- R9: In PWM mode the wrap flag is set by the step that leaves zero after a downward run. This is once per period, and not at the first step after the control write.
- R10: Writing the flag register (address 4) clears each flag whose data bit is 1 and leaves flags written with 0 unchanged.
- R11: A write to the count register (address 1) loads the count on that clock and takes priority over a counting step. Reads at addresses 0 to 4 return control, count, compare, capture and flags, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 count, 2 compare, 4 flags) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| cap_pin | input | 1 | Asynchronous capture input |
| cmp_pin | output | 1 | Compare waveform output |
| irq_ovf | output | 1 | Wrap flag |
| irq_cmp | output | 1 | Compare match flag |
| irq_cap | output | 1 | Capture flag |

## Verification
A register write is visible on the next read, and the first counting step comes one clock later. The match flag and the pin change arrive one clock after the count reads the compare value, and the wrap flag arrives on the step after the count reads 0xFFFF or returns to zero. A capture lands four clocks after the pin moves when the filter is off, and up to eight clocks after when it is on, so the bench waits ten to twelve clocks before judging a capture or its absence. PWM duty is counted over a full 2·TOP window taken after one settling period, which makes the result independent of phase; the 8- and 64-clock prescalers are likewise judged over windows that are whole multiples of their period.

// File: rtl/tmr16_pkg.sv
// Shared constants for the 16-bit capture/PWM timer: register addresses,
// control field positions, flag indices and the PWM top-value function.
package tmr16_pkg;
    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int CTRL_W  = 6;
    localparam int N_FLAGS = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMP   = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG  = 3'd4;

    localparam int C_CLK_LSB = 0;
    localparam int C_RES_LSB = 2;
    localparam int C_RISE    = 4;
    localparam int C_FILT    = 5;

    localparam int FLG_OVF = 0;
    localparam int FLG_CMP = 1;
    localparam int FLG_CAP = 2;

    // Turnaround value: all ones in normal mode, 2^(res+7)-1 in PWM modes.
    function automatic logic [CNT_W-1:0] pwm_top(input logic [1:0] res);
        if (res == 2'd0)
            return '1;
        return CNT_W'((32'd1 << (32'(res) + 32'd7)) - 32'd1);
    endfunction
endpackage

// File: rtl/tmr16_prescale.sv
// Clock-enable prescaler. A free-running counter produces a one-cycle
// tick every clock, every DIV_MID clocks or every DIV_HI clocks, or never.
// Assumes DIV_MID and DIV_HI are powers of two with DIV_MID <= DIV_HI.
module tmr16_prescale #(
    parameter int DIV_MID = 8,
    parameter int DIV_HI  = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int PW = $clog2(DIV_HI);

    logic [PW-1:0] pcnt;

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end

    // Tick selection per enable setting.
    always_comb begin
        case (sel)
            2'd0:    tick = 1'b0;
            2'd1:    tick = 1'b1;
            2'd2:    tick = (pcnt & PW'(DIV_MID - 1)) == PW'(DIV_MID - 1);
            default: tick = pcnt == PW'(DIV_HI - 1);
        endcase
    end
endmodule

// File: rtl/tmr16_capfront.sv
// Capture front end: synchronises the asynchronous pin, optionally
// requires FILT_N equal consecutive samples before accepting a new level,
// and emits a one-cycle event on accepted edges of the selected polarity.
// Assumes SYNC_N >= 2 and FILT_N >= 2.
module tmr16_capfront #(
    parameter int SYNC_N = 2,
    parameter int FILT_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic filt_en,
    input  logic rise_sel,
    output logic evt
);
    logic [SYNC_N-1:0] sync_q;
    logic [FILT_N-1:0] hist_q;
    logic              samp;
    logic              lvl_q;
    logic              lvl_nxt;

    assign samp = sync_q[SYNC_N-1];

    // Synchroniser chain and sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin};
            hist_q <= {hist_q[FILT_N-2:0], samp};
        end
    end

    // Accepted level: raw sample, or a full run of equal samples.
    always_comb begin
        if (!filt_en)
            lvl_nxt = samp;
        else if (&hist_q)
            lvl_nxt = 1'b1;
        else if (~|hist_q)
            lvl_nxt = 1'b0;
        else
            lvl_nxt = lvl_q;
    end

    // Level register and polarity-qualified edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            evt   <= 1'b0;
        end else begin
            lvl_q <= lvl_nxt;
            evt   <= (lvl_nxt != lvl_q) && (lvl_nxt == rise_sel);
        end
    end
endmodule

// File: rtl/tmr16_core.sv
// Counter core: up-counting or up/down counting, compare match, waveform
// pin, capture register and write-1-to-clear flags. A count write beats
// a counting step and suppresses that step's match and wrap events.
module tmr16_core
    import tmr16_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               ctrl_wr,
    input  logic               cnt_wr,
    input  logic [1:0]         res,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [CNT_W-1:0]   cmp_val,
    input  logic               cap_evt,
    input  logic [N_FLAGS-1:0] flag_clr,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CNT_W-1:0]   cap_q,
    output logic [N_FLAGS-1:0] flags,
    output logic               wave
);
    logic               pwm_on;
    logic [CNT_W-1:0]   top;
    logic               dir_up;
    logic               at_bot;
    logic               at_top;
    logic               eff_up;
    logic               step_ok;
    logic               match;
    logic               wrap;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [N_FLAGS-1:0] flag_set;

    assign pwm_on  = res != 2'd0;
    assign top     = pwm_top(res);
    assign at_bot  = cnt_q == '0;
    assign at_top  = cnt_q >= top;
    // Direction used for this step: forced upward at zero, downward at TOP.
    assign eff_up  = at_bot ? 1'b1 : (at_top ? 1'b0 : dir_up);
    assign step_ok = tick && !cnt_wr;
    assign match   = step_ok && (cnt_q == cmp_val);
    assign wrap    = step_ok && (pwm_on ? (at_bot && !dir_up) : (cnt_q == '1));

    // Next count for one counting step.
    always_comb begin
        if (pwm_on && !eff_up)
            cnt_nxt = cnt_q - 1'b1;
        else
            cnt_nxt = cnt_q + 1'b1;
    end

    // Count register: load has priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_wr)
            cnt_q <= wr_data;
        else if (tick)
            cnt_q <= cnt_nxt;
    end

    // Direction memory for PWM; restarts upward on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_wr)
            dir_up <= 1'b1;
        else if (step_ok && pwm_on)
            dir_up <= eff_up;
    end

    // Waveform pin: toggle in normal mode, clear-up/set-down in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wave <= 1'b0;
        else if (match)
            wave <= pwm_on ? !eff_up : !wave;
    end

    // Capture register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cap_q <= '0;
        else if (cap_evt)
            cap_q <= cnt_q;
    end

    assign flag_set = {cap_evt, match, wrap};

    // Sticky flags with write-1-to-clear; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~flag_clr) | flag_set;
    end
endmodule

// File: rtl/cap_pwm_timer16.sv
// Top level of the 16-bit capture/PWM timer. Holds the control and
// compare registers, decodes the write port, muxes the read port and
// joins the prescaler, capture front end and counter core.
// Assumes synchronous active-low reset and a single clock domain apart
// from cap_pin, which is synchronised inside.
module cap_pwm_timer16
    import tmr16_pkg::*;
#(
    parameter int DIV_MID = 8,
    parameter int DIV_HI  = 64,
    parameter int SYNC_N  = 2,
    parameter int FILT_N  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              cap_pin,
    output logic              cmp_pin,
    output logic              irq_ovf,
    output logic              irq_cmp,
    output logic              irq_cap
);
    logic [CTRL_W-1:0]  ctrl_q;
    logic [CNT_W-1:0]   cmp_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   cap_q;
    logic [N_FLAGS-1:0] flags;
    logic [N_FLAGS-1:0] flag_clr;
    logic               ctrl_wr;
    logic               cnt_wr;
    logic               cmp_wr;
    logic               tick;
    logic               cap_evt;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign cnt_wr   = wr_en && (wr_addr == A_COUNT);
    assign cmp_wr   = wr_en && (wr_addr == A_CMP);
    assign flag_clr = (wr_en && (wr_addr == A_FLAG)) ? wr_data[N_FLAGS-1:0] : '0;

    // Control and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= wr_data[CTRL_W-1:0];
            if (cmp_wr)
                cmp_q <= wr_data;
        end
    end

    tmr16_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (ctrl_q[C_CLK_LSB +: 2]),
        .tick  (tick)
    );

    tmr16_capfront #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .filt_en  (ctrl_q[C_FILT]),
        .rise_sel (ctrl_q[C_RISE]),
        .evt      (cap_evt)
    );

    tmr16_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ctrl_wr  (ctrl_wr),
        .cnt_wr   (cnt_wr),
        .res      (ctrl_q[C_RES_LSB +: 2]),
        .wr_data  (wr_data),
        .cmp_val  (cmp_q),
        .cap_evt  (cap_evt),
        .flag_clr (flag_clr),
        .cnt_q    (cnt_q),
        .cap_q    (cap_q),
        .flags    (flags),
        .wave     (cmp_pin)
    );

    // Combinational read mux.
    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = CNT_W'(ctrl_q);
            A_COUNT: rd_data = cnt_q;
            A_CMP:   rd_data = cmp_q;
            A_CAPT:  rd_data = cap_q;
            A_FLAG:  rd_data = CNT_W'(flags);
            default: rd_data = '0;
        endcase
    end

    assign irq_ovf = flags[FLG_OVF];
    assign irq_cmp = flags[FLG_CMP];
    assign irq_cap = flags[FLG_CAP];
endmodule

// File: rtl/tmr16_chk.sv
// Property checker for cap_pwm_timer16, attached with bind below.
module tmr16_chk
    import tmr16_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CTRL_W-1:0]  ctrl_q,
    input logic               ctrl_wr,
    input logic               cnt_wr,
    input logic               tick,
    input logic [CNT_W-1:0]   cnt_q,
    input logic [CNT_W-1:0]   cmp_q,
    input logic [CNT_W-1:0]   cap_q,
    input logic [N_FLAGS-1:0] flags,
    input logic [N_FLAGS-1:0] flag_clr
);
    logic [1:0]       res;
    logic [CNT_W-1:0] top;

    assign res = ctrl_q[C_RES_LSB +: 2];
    assign top = pwm_top(res);

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr) && $past(ctrl_q[C_CLK_LSB +: 2]) == 2'd0) |-> cnt_q == $past(cnt_q)); // R2

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !cnt_wr && res == 2'd0 && cnt_q == 16'hFFFF) |-> (flags[FLG_OVF] && cnt_q == '0)); // R3

    AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !cnt_wr && cnt_q == cmp_q) |-> flags[FLG_CMP]); // R4

    AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FLG_CAP]) |-> cap_q == $past(cnt_q)); // R5

    AST_PWM_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tick && !cnt_wr && !ctrl_wr && res != 2'd0 && cnt_q <= top)
        |-> ((cnt_q == $past(cnt_q) + 16'd1 || cnt_q == $past(cnt_q) - 16'd1) && cnt_q <= top)); // R7

    AST_FLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flags & $past(flags)) & ~$past(flag_clr)) == '0); // R10
endmodule

bind cap_pwm_timer16 tmr16_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_q   (ctrl_q),
    .ctrl_wr  (ctrl_wr),
    .cnt_wr   (cnt_wr),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .cmp_q    (cmp_q),
    .cap_q    (cap_q),
    .flags    (flags),
    .flag_clr (flag_clr)
);

// File: tb/cap_pwm_timer16_test.sv
`timescale 1ns/1ps
module cap_pwm_timer16_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cap_pin = 1'b0;
    logic        cmp_pin;
    logic        irq_ovf, irq_cmp, irq_cap;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cap_pwm_timer16 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_pin(cap_pin), .cmp_pin(cmp_pin), .irq_ovf(irq_ovf),
        .irq_cmp(irq_cmp), .irq_cap(irq_cap)
    );

    // Expected PWM turnaround value for a resolution code.
    function automatic int exp_top(input int res);
        return (1 << (res + 7)) - 1;
    endfunction

    // Expected high clocks per PWM period.
    function automatic int exp_high(input int c);
        return 2 * c;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wreg(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rreg(input logic [2:0] a, output int v);
        rd_addr = a;
        #0.5;
        v = int'(rd_data);
    endtask

    task automatic run_pwm(input int res, input int c);
        int top, v, hi, mx;
        top = exp_top(res);
        wreg(3'd0, 16'h0000);
        wreg(3'd1, 16'h0000);
        wreg(3'd2, 16'(c));
        wreg(3'd4, 16'h0007);
        wreg(3'd0, 16'((res << 2) | 1));
        rreg(3'd1, v); chk("R7 pwm start count", v, 0);
        for (int k = 1; k <= 2 * top; k++) begin
            step();
            if (k == top) begin rreg(3'd1, v); chk("R7 pwm reaches top", v, top); end
            if (k == top + 1) begin rreg(3'd1, v); chk("R7 pwm turns down", v, top - 1); end
            if (k == 2 * top) begin
                rreg(3'd1, v); chk("R7 pwm back at zero", v, 0);
                chk("R9 no wrap flag yet", int'(irq_ovf), 0);
            end
        end
        step();
        chk("R9 wrap flag leaving zero", int'(irq_ovf), 1);
        rreg(3'd1, v); chk("R7 pwm turns up", v, 1);
        hi = 0; mx = 0;
        for (int k = 0; k < 2 * top; k++) begin
            step();
            if (cmp_pin) hi++;
            rreg(3'd1, v);
            if (v > mx) mx = v;
        end
        chk("R7 pwm max count", mx, top);
        chk("R8 pwm high clocks", hi, exp_high(c));
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog got=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, c, k, base;
        logic prev;
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1: reset state.
        for (int a = 0; a < 5; a++) begin
            rreg(3'(a), v); chk("R1 register zero after reset", v, 0);
        end
        chk("R1 pin and irqs zero", int'({cmp_pin, irq_ovf, irq_cmp, irq_cap}), 0);

        // R11: count load and readback.
        for (int i = 0; i < 6; i++) begin
            c = int'($urandom_range(0, 65535));
            wreg(3'd1, 16'(c));
            rreg(3'd1, v); chk("R11 count load", v, c);
        end
        wreg(3'd2, 16'h1357);
        rreg(3'd2, v); chk("R11 compare readback", v, 16'h1357);
        wreg(3'd0, 16'h0000);

        // R2: stopped counter holds.
        wreg(3'd1, 16'h4000);
        repeat (20) step();
        rreg(3'd1, v); chk("R2 stopped counter holds", v, 16'h4000);

        // R2: every-clock counting with random run lengths.
        for (int i = 0; i < 4; i++) begin
            base = int'($urandom_range(0, 60000));
            k = int'($urandom_range(1, 40));
            wreg(3'd0, 16'h0000);
            wreg(3'd1, 16'(base));
            wreg(3'd0, 16'h0001);
            rreg(3'd1, v); chk("R2 no step before first clock", v, base);
            repeat (k) step();
            rreg(3'd1, v); chk("R2 count per clock", v, base + k);
        end

        // R2: divide by 8 and by 64.
        wreg(3'd0, 16'h0000);
        wreg(3'd1, 16'h0100);
        wreg(3'd0, 16'h0002);
        rreg(3'd1, v); chk("R2 div8 start", v, 16'h0100);
        repeat (64) step();
        rreg(3'd1, v); chk("R2 div8 advance", v, 16'h0108);
        wreg(3'd0, 16'h0000);
        wreg(3'd1, 16'h0200);
        wreg(3'd0, 16'h0003);
        repeat (128) step();
        rreg(3'd1, v); chk("R2 div64 advance", v, 16'h0202);

        // R3: wrap from 0xFFFF.
        wreg(3'd0, 16'h0000);
        wreg(3'd2, 16'h8000);
        wreg(3'd1, 16'hFFFD);
        wreg(3'd4, 16'h0007);
        wreg(3'd0, 16'h0001);
        step(); step();
        rreg(3'd1, v); chk("R3 count at max", v, 16'hFFFF);
        chk("R3 no flag before wrap", int'(irq_ovf), 0);
        step();
        rreg(3'd1, v); chk("R3 count wraps to zero", v, 0);
        chk("R3 wrap flag set", int'(irq_ovf), 1);

        // R10: write-1-to-clear.
        wreg(3'd0, 16'h0000);
        wreg(3'd4, 16'h0006);
        chk("R10 zero bit leaves flag", int'(irq_ovf), 1);
        rreg(3'd4, v); chk("R10 flag register bit0", v & 1, 1);
        wreg(3'd4, 16'h0001);
        chk("R10 one bit clears flag", int'(irq_ovf), 0);

        // R4: compare match in normal mode.
        for (int i = 0; i < 4; i++) begin
            c = int'($urandom_range(16, 16'hFFF0));
            wreg(3'd0, 16'h0000);
            wreg(3'd2, 16'(c));
            wreg(3'd1, 16'(c - 3));
            wreg(3'd4, 16'h0007);
            prev = cmp_pin;
            wreg(3'd0, 16'h0001);
            repeat (3) step();
            rreg(3'd1, v); chk("R4 count reaches compare", v, c);
            chk("R4 no match flag yet", int'(irq_cmp), 0);
            step();
            chk("R4 match flag", int'(irq_cmp), 1);
            chk("R4 pin toggles", int'(cmp_pin), int'(!prev));
        end

        // R5: rising capture, falling edge ignored.
        wreg(3'd0, 16'h0010);
        wreg(3'd1, 16'h1111);
        wreg(3'd4, 16'h0007);
        cap_pin = 1'b1;
        repeat (10) step();
        chk("R5 rising capture flag", int'(irq_cap), 1);
        rreg(3'd3, v); chk("R5 capture value", v, 16'h1111);
        wreg(3'd1, 16'h2222);
        wreg(3'd4, 16'h0007);
        cap_pin = 1'b0;
        repeat (10) step();
        chk("R5 falling ignored flag", int'(irq_cap), 0);
        rreg(3'd3, v); chk("R5 falling ignored value", v, 16'h1111);

        // R5: falling select.
        wreg(3'd0, 16'h0000);
        wreg(3'd1, 16'h3333);
        cap_pin = 1'b1;
        repeat (10) step();
        chk("R5 rising ignored under falling select", int'(irq_cap), 0);
        cap_pin = 1'b0;
        repeat (10) step();
        chk("R5 falling capture flag", int'(irq_cap), 1);
        rreg(3'd3, v); chk("R5 falling capture value", v, 16'h3333);

        // R6: filter off, one-clock pulse captured.
        wreg(3'd0, 16'h0010);
        wreg(3'd1, 16'h4444);
        wreg(3'd4, 16'h0007);
        cap_pin = 1'b1; step(); cap_pin = 1'b0;
        repeat (10) step();
        chk("R6 unfiltered pulse flag", int'(irq_cap), 1);
        rreg(3'd3, v); chk("R6 unfiltered pulse value", v, 16'h4444);

        // R6: filter on, three clocks rejected, four accepted.
        wreg(3'd0, 16'h0030);
        wreg(3'd1, 16'h5555);
        wreg(3'd4, 16'h0007);
        repeat (6) step();
        cap_pin = 1'b1; repeat (3) step(); cap_pin = 1'b0;
        repeat (12) step();
        chk("R6 filtered short pulse flag", int'(irq_cap), 0);
        rreg(3'd3, v); chk("R6 filtered short pulse value", v, 16'h4444);
        cap_pin = 1'b1; repeat (4) step(); cap_pin = 1'b0;
        repeat (12) step();
        chk("R6 filtered long pulse flag", int'(irq_cap), 1);
        rreg(3'd3, v); chk("R6 filtered long pulse value", v, 16'h5555);

        // R7 R8 R9: PWM at each resolution, directed extremes and random duty.
        run_pwm(1, 0);
        run_pwm(1, 255);
        run_pwm(1, int'($urandom_range(1, 254)));
        run_pwm(2, int'($urandom_range(1, 510)));
        run_pwm(3, int'($urandom_range(1, 1022)));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule